// File: doc/BRIEF.md
# LED Pixel FIFO and Interrupt Front End

This block sits between a 32-bit register port and a serial LED waveform generator. Software or a DMA engine writes pixel words into a data register. The block queues them in a 32-entry FIFO and hands them to the serializer through a valid/ready stream. The block also stores the configuration words that the serializer consumes: the control word, the bit timing and the reset timing.

A frame starts when software writes the control register with its run bit set while no frame is active. A single request rule then keeps the FIFO topped up. While a frame runs, a FIFO fill level at or below the programmed threshold raises one of two requests. In CPU mode it sets a sticky request status bit that can raise an interrupt. In DMA mode it drives a live DMA request line.

When the serializer pulses its frame-done input, the frame ends and a sticky finished status bit is set. The status word also reports the live FIFO fill level, so an interrupt handler can size its next burst.

Top module: `led_fifo_irq_front`

## Requirements
- R1: After reset, every register reads zero, the FIFO is empty (`pix_valid` low), and `irq`, `dma_req` and `ser_start` are low.
- R2: The configuration registers read back only their defined fields, and every other bit reads zero. Field masks: control (0x00) 0x1FFF01C1, bit timing (0x04) 0x07FF07FF, reset timing (0x0C) 0x1FFF03FF, DMA control (0x18) 0x0000003F, interrupt enable (0x1C) 0x00000023. The data register (0x14) and unmapped offsets read zero.
- R3: Each write to the data register (0x14) pushes one word when the FIFO is not full. Words leave on `pix_data` in write order. The status register (0x20) bits 15:10 hold the live fill level.
- R4: A data write while the FIFO holds 32 words is dropped. The fill level stays at 32 and the dropped word never appears on `pix_data`.
- R5: A control write with bit 0 set while no frame is active starts a frame and gives a one-cycle `ser_start` pulse in the cycle after the write. The same write during an active frame gives no pulse.
- R6: In CPU mode (DMA control bit 5 clear), status bit 1 becomes set one cycle after the fill level is at or below the threshold (DMA control bits 4:0) during an active frame. A level above the threshold does not set it.
- R7: In DMA mode (DMA control bit 5 set), `dma_req` is high exactly while a frame is active and the level is at or below the threshold. Status bit 1 is not set in this mode.
- R8: A `frame_done` pulse ends the active frame, so `dma_req` and further requests stop. It also sets status bit 0 on the next cycle.
- R9: Writing 1 to status bit 0 or bit 1 clears that bit, and writing 0 leaves it unchanged. If the set condition holds in the same cycle as the clear, the bit stays set.
- R10: `irq` is interrupt enable bit 5 ANDed with the OR of (enable bit 0 AND status bit 0) and (enable bit 1 AND status bit 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pix_valid | output | 1 | FIFO holds a word |
| pix_data | output | 32 | Oldest FIFO word |
| pix_ready | input | 1 | Serializer takes the word this cycle |
| ser_start | output | 1 | One-cycle frame start pulse |
| ser_ctrl | output | 32 | Stored control word |
| ser_bit_tim | output | 32 | Stored bit timing word |
| ser_rst_tim | output | 32 | Stored reset timing word |
| frame_done | input | 1 | Serializer frame-complete pulse |
| irq | output | 1 | Interrupt line |
| dma_req | output | 1 | DMA request line |

## Verification
Register readback is tried with all-ones write patterns. These expose any reserved bit that leaks through, and the data and unmapped offsets must still read zero. The FIFO is filled with a distinct marker word followed by a counting sequence and then over-filled. This separates correct ordering from pointer wrap faults, and a dropped overflow word from one that overwrites storage. The request logic is drained one word at a time around a threshold of 4, in CPU mode and then in DMA mode. This tells the "at or below" comparison apart from "below", and sticky status apart from the live DMA line. Clears are issued while the set condition still holds and after it has gone, which shows whether set wins over clear.

// File: rtl/led_fe_pkg.sv
// Package: register offsets, field masks and bit positions shared by the
// LED FIFO front end. Assumes byte offsets on a 32-bit register port.
package led_fe_pkg;
    localparam int DW = 32;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_BTIM = 8'h04;
    localparam logic [7:0] OFS_RTIM = 8'h0C;
    localparam logic [7:0] OFS_DATA = 8'h14;
    localparam logic [7:0] OFS_DMAC = 8'h18;
    localparam logic [7:0] OFS_IEN  = 8'h1C;
    localparam logic [7:0] OFS_STAT = 8'h20;

    localparam logic [DW-1:0] MSK_CTRL = 32'h1FFF_01C1;
    localparam logic [DW-1:0] MSK_BTIM = 32'h07FF_07FF;
    localparam logic [DW-1:0] MSK_RTIM = 32'h1FFF_03FF;
    localparam logic [DW-1:0] MSK_DMAC = 32'h0000_003F;
    localparam logic [DW-1:0] MSK_IEN  = 32'h0000_0023;

    localparam int CTRL_RUN_BIT = 0;
    localparam int DMAC_EN_BIT  = 5;
    localparam int TRIG_W       = 5;
    localparam int IEN_FIN_BIT  = 0;
    localparam int IEN_REQ_BIT  = 1;
    localparam int IEN_GLB_BIT  = 5;
    localparam int STAT_LVL_LSB = 10;
endpackage

// File: rtl/led_fe_fifo.sv
// Module: synchronous pixel FIFO. A push when full is dropped and a pop
// when empty is ignored. Read data shows the oldest word combinationally.
// Assumes one clock domain and a single writer and reader.
module led_fe_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DW-1:0]                wdata,
    input  logic                         pop,
    output logic [DW-1:0]                rdata,
    output logic                         valid,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign valid   = (level != '0);
    assign full    = (level == LVL_W'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && valid;
    assign rdata   = mem[rd_ptr];

    // Store an accepted word at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Advance the pointers and track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            if (push_ok && !pop_ok)      level <= level + 1'b1;
            else if (pop_ok && !push_ok) level <= level - 1'b1;
        end
    end

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));
    a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (level == LVL_W'(DEPTH)));
    a_r3_push_count: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop) |=> (level == $past(level) + 1'b1));
endmodule

// File: rtl/led_fe_cfg.sv
// Module: configuration register bank and readback mux. It stores only the
// defined fields of each register. Data and unmapped offsets read zero.
// Assumes the status word is assembled outside and passed in.
module led_fe_cfg
    import led_fe_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     stat_word,
    output logic [DW-1:0]     rdata,
    output logic [DW-1:0]     ctrl_q,
    output logic [DW-1:0]     btim_q,
    output logic [DW-1:0]     rtim_q,
    output logic [DW-1:0]     dmac_q,
    output logic [DW-1:0]     ien_q
);
    // Capture masked write data into the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            btim_q <= '0;
            rtim_q <= '0;
            dmac_q <= '0;
            ien_q  <= '0;
        end else if (we) begin
            if (addr == ADDR_W'(OFS_CTRL)) ctrl_q <= wdata & MSK_CTRL;
            if (addr == ADDR_W'(OFS_BTIM)) btim_q <= wdata & MSK_BTIM;
            if (addr == ADDR_W'(OFS_RTIM)) rtim_q <= wdata & MSK_RTIM;
            if (addr == ADDR_W'(OFS_DMAC)) dmac_q <= wdata & MSK_DMAC;
            if (addr == ADDR_W'(OFS_IEN))  ien_q  <= wdata & MSK_IEN;
        end
    end

    // Select the read word for the current offset.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_CTRL)) rdata = ctrl_q;
        if (addr == ADDR_W'(OFS_BTIM)) rdata = btim_q;
        if (addr == ADDR_W'(OFS_RTIM)) rdata = rtim_q;
        if (addr == ADDR_W'(OFS_DMAC)) rdata = dmac_q;
        if (addr == ADDR_W'(OFS_IEN))  rdata = ien_q;
        if (addr == ADDR_W'(OFS_STAT)) rdata = stat_word;
    end

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_q & ~MSK_CTRL) == '0) && ((ien_q & ~MSK_IEN) == '0));
endmodule

// File: rtl/led_fe_evt.sv
// Module: frame state, sticky status bits, interrupt and DMA request.
// A frame runs from an accepted start until frame_done. One threshold
// drives either the CPU request bit or the DMA line. Status bits are
// write-one-to-clear, and a set in the same cycle wins.
module led_fe_evt
    import led_fe_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             frame_done,
    input  logic [LVL_W-1:0] level,
    input  logic [TRIG_W-1:0] trig,
    input  logic             dma_en,
    input  logic             ien_glb,
    input  logic             ien_fin,
    input  logic             ien_req,
    input  logic             clr_fin,
    input  logic             clr_req,
    output logic             busy,
    output logic             ser_start,
    output logic             st_fin,
    output logic             st_req,
    output logic             irq,
    output logic             dma_req
);
    logic low;

    assign low     = (level <= LVL_W'(trig));
    assign dma_req = busy && dma_en && low;
    assign irq     = ien_glb && ((ien_fin && st_fin) || (ien_req && st_req));

    // Track the active frame and issue the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            ser_start <= 1'b0;
        end else begin
            ser_start <= start_req && !busy;
            if (frame_done)              busy <= 1'b0;
            else if (start_req && !busy) busy <= 1'b1;
        end
    end

    // Update the sticky status bits, with a set winning over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_fin <= 1'b0;
            st_req <= 1'b0;
        end else begin
            st_fin <= (st_fin && !clr_fin) || frame_done;
            st_req <= (st_req && !clr_req) || (busy && !dma_en && low);
        end
    end

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ser_start |=> !ser_start);
    a_r6_req_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_req) |-> $past(busy && !dma_en));
    a_r8_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (st_fin && !busy));
    a_r9_clear_fin: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_fin && !frame_done) |=> !st_fin);
    a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ien_glb);
endmodule

// File: rtl/led_fifo_irq_front.sv
// Module: top of the LED pixel FIFO and interrupt front end. It decodes
// register writes into data pushes, frame starts and status clears. It
// assembles the status word with the live fill level. Assumes the
// serializer consumes pix_data on pix_valid && pix_ready.
module led_fifo_irq_front
    import led_fe_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              pix_valid,
    output logic [31:0]       pix_data,
    input  logic              pix_ready,
    output logic              ser_start,
    output logic [31:0]       ser_ctrl,
    output logic [31:0]       ser_bit_tim,
    output logic [31:0]       ser_rst_tim,
    input  logic              frame_done,
    output logic              irq,
    output logic              dma_req
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [DW-1:0]    dmac_q, ien_q, stat_word;
    logic [LVL_W-1:0] level;
    logic             full, busy, st_fin, st_req;
    logic             wr_data, wr_ctrl, wr_stat;

    assign wr_data = reg_we && (reg_addr == ADDR_W'(OFS_DATA));
    assign wr_ctrl = reg_we && (reg_addr == ADDR_W'(OFS_CTRL));
    assign wr_stat = reg_we && (reg_addr == ADDR_W'(OFS_STAT));

    // Assemble the status word from the sticky bits and the fill level.
    always_comb begin
        stat_word = '0;
        stat_word[0] = st_fin;
        stat_word[1] = st_req;
        stat_word[STAT_LVL_LSB +: LVL_W] = level;
    end

    led_fe_fifo #(.DW(DW), .DEPTH(DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(wr_data), .wdata(reg_wdata),
        .pop(pix_valid && pix_ready), .rdata(pix_data),
        .valid(pix_valid), .full(full), .level(level)
    );

    led_fe_cfg #(.ADDR_W(ADDR_W)) i_cfg (
        .clk(clk), .rst_n(rst_n),
        .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .stat_word(stat_word), .rdata(reg_rdata),
        .ctrl_q(ser_ctrl), .btim_q(ser_bit_tim), .rtim_q(ser_rst_tim),
        .dmac_q(dmac_q), .ien_q(ien_q)
    );

    led_fe_evt #(.LVL_W(LVL_W)) i_evt (
        .clk(clk), .rst_n(rst_n),
        .start_req(wr_ctrl && reg_wdata[CTRL_RUN_BIT]),
        .frame_done(frame_done), .level(level),
        .trig(dmac_q[TRIG_W-1:0]), .dma_en(dmac_q[DMAC_EN_BIT]),
        .ien_glb(ien_q[IEN_GLB_BIT]), .ien_fin(ien_q[IEN_FIN_BIT]),
        .ien_req(ien_q[IEN_REQ_BIT]),
        .clr_fin(wr_stat && reg_wdata[0]), .clr_req(wr_stat && reg_wdata[1]),
        .busy(busy), .ser_start(ser_start),
        .st_fin(st_fin), .st_req(st_req), .irq(irq), .dma_req(dma_req)
    );

    a_r7_dma_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (busy && !full));
endmodule

// File: tb/test_led_fifo_irq_front.sv
module test_led_fifo_irq_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pix_valid, ser_start, irq, dma_req;
    logic [31:0] pix_data, ser_ctrl, ser_bit_tim, ser_rst_tim;
    logic        pix_ready = 1'b0;
    logic        frame_done = 1'b0;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    led_fifo_irq_front i_led_fifo_irq_front (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .ser_start(ser_start), .ser_ctrl(ser_ctrl), .ser_bit_tim(ser_bit_tim),
        .ser_rst_tim(ser_rst_tim), .frame_done(frame_done), .irq(irq),
        .dma_req(dma_req)
    );

    // {offset, write data, expected readback}
    localparam logic [71:0] VEC [7] = '{
        {8'h00, 32'hFFFF_FFFE, 32'h1FFF_01C0},
        {8'h04, 32'hFFFF_FFFF, 32'h07FF_07FF},
        {8'h0C, 32'hFFFF_FFFF, 32'h1FFF_03FF},
        {8'h18, 32'h0000_001F, 32'h0000_001F},
        {8'h1C, 32'hFFFF_FFFF, 32'h0000_0023},
        {8'h14, 32'h1234_5678, 32'h0000_0000},
        {8'h08, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd(8'h00, v); chk("R1 ctrl", v, 0);
        rd(8'h20, v); chk("R1 status", v, 0);
        chk("R1 outputs", {pix_valid, irq, dma_req, ser_start}, 4'b0);

        // R2: readback table
        for (int i = 0; i < 7; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], v);
            chk("R2 readback", v, VEC[i][31:0]);
        end
        chk("R5 no start without run bit", {31'b0, ser_start}, 0);

        // R3: one word queued by the table
        rd(8'h20, v); chk("R3 level 1", v, 32'h0000_0400);
        chk("R3 head word", pix_data, 32'h1234_5678);

        // R4: fill to 32 then overflow
        for (int i = 1; i < 32; i++) wr(8'h14, i);
        rd(8'h20, v); chk("R4 level 32", v, 32'h0000_8000);
        wr(8'h14, 32'hDEAD_BEEF);
        rd(8'h20, v); chk("R4 drop keeps 32", v, 32'h0000_8000);

        // R3: drain in order
        pix_ready = 1'b1;
        for (int i = 0; i < 32; i++) begin
            chk("R3 order", pix_data, (i == 0) ? 32'h1234_5678 : i);
            @(negedge clk);
        end
        pix_ready = 1'b0;
        chk("R4 dropped word absent", {31'b0, pix_valid}, 0);

        // R6: CPU mode, threshold 4, eight words queued
        wr(8'h18, 32'h0000_0004);
        for (int i = 0; i < 8; i++) wr(8'h14, 32'hA0 + i);
        wr(8'h00, 32'h0000_0001);
        chk("R5 start pulse", {31'b0, ser_start}, 1);
        @(negedge clk);
        chk("R5 pulse one cycle", {31'b0, ser_start}, 0);
        rd(8'h20, v); chk("R6 above trig no req", v, 32'h0000_2000);
        pix_ready = 1'b1;
        repeat (4) @(negedge clk);
        pix_ready = 1'b0;
        rd(8'h20, v); chk("R6 not yet set", v, 32'h0000_1000);
        @(negedge clk);
        rd(8'h20, v); chk("R6 req at trig", v, 32'h0000_1002);
        chk("R10 irq from req", {31'b0, irq}, 1);
        wr(8'h00, 32'h0000_0001);
        chk("R5 no start while busy", {31'b0, ser_start}, 0);
        wr(8'h20, 32'h0000_0000);
        rd(8'h20, v); chk("R9 zero write no effect", v, 32'h0000_1002);
        wr(8'h20, 32'h0000_0002);
        rd(8'h20, v); chk("R9 set wins", v, 32'h0000_1002);

        // R7: DMA mode
        wr(8'h18, 32'h0000_0024);
        chk("R7 dma_req", {31'b0, dma_req}, 1);
        wr(8'h20, 32'h0000_0002);
        rd(8'h20, v); chk("R7 no cpu req in dma", v, 32'h0000_1000);
        chk("R10 irq low", {31'b0, irq}, 0);

        // R8: frame done
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        chk("R8 dma_req stops", {31'b0, dma_req}, 0);
        rd(8'h20, v); chk("R8 fin set", v, 32'h0000_1001);
        chk("R10 irq from fin", {31'b0, irq}, 1);
        wr(8'h1C, 32'h0000_0002);
        chk("R10 global off", {31'b0, irq}, 0);
        wr(8'h1C, 32'h0000_0021);
        chk("R10 fin enabled", {31'b0, irq}, 1);
        wr(8'h20, 32'h0000_0001);
        rd(8'h20, v); chk("R9 fin cleared", v, 32'h0000_1000);
        chk("R9 irq cleared", {31'b0, irq}, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule